// File: doc/BRIEF.md
# Sample-Only Boundary Scan Test Port

This block is a serial test port for a memory device. It is driven by a test clock and a mode-select line, and shifts data in from a serial input and out on a serial output. A 16-state controller steps through capture, shift and update phases for two scan paths. The first path is a 3-bit instruction path. The second is a data path chosen by the current instruction: a 1-bit bypass stage, a 32-bit identification word or a 51-cell boundary register.

The boundary register can only capture the parallel pad inputs and shift them out. It has no update stage, so the port never drives pads. Two instruction codes request that the device's data output drivers go to high impedance, through the `drv_hiz` output. There is no dedicated reset pin. The controller, and with it the instruction, returns to a known state after five test-clock cycles with mode-select held high.

Controller states, each with its mode-select-low / mode-select-high successor:

- IDLE_RESET → RUN_IDLE / IDLE_RESET
- RUN_IDLE → RUN_IDLE / PICK_DR
- PICK_DR → GRAB_DR / PICK_IR
- GRAB_DR → SHIFT_DR / EXIT1_DR
- SHIFT_DR → SHIFT_DR / EXIT1_DR
- EXIT1_DR → PAUSE_DR / APPLY_DR
- PAUSE_DR → PAUSE_DR / EXIT2_DR
- EXIT2_DR → SHIFT_DR / APPLY_DR
- APPLY_DR → RUN_IDLE / PICK_DR
- PICK_IR → GRAB_IR / IDLE_RESET
- GRAB_IR → SHIFT_IR / EXIT1_IR
- SHIFT_IR → SHIFT_IR / EXIT1_IR
- EXIT1_IR → PAUSE_IR / APPLY_IR
- PAUSE_IR → PAUSE_IR / EXIT2_IR
- EXIT2_IR → SHIFT_IR / APPLY_IR
- APPLY_IR → RUN_IDLE / PICK_DR

Top module: `scan_tap`

## Requirements
- R1: Five consecutive rising edges of `tck` with `tms` high bring the controller to IDLE_RESET from any state. While the controller is in IDLE_RESET, and in every state other than the two shift states, `tdo_en` is low.
- R2: In IDLE_RESET the instruction becomes 3'b001, the identification code. Capturing in that mode loads `ID_VALUE` with bit 0 forced to 1, and the word is shifted out least significant bit first.
- R3: GRAB_IR loads 3'b001 into the instruction shift stage. The stage shifts least significant bit first, with `tdi` entering at the top bit. The shifted value becomes the instruction on the rising edge that leaves APPLY_IR.
- R4: Codes 3'b011, 3'b101, 3'b110 and 3'b111 select the 1-bit bypass stage. It captures 0, so a scan returns 0 followed by `tdi` delayed by one clock.
- R5: Code 3'b100 selects sampling. The boundary register captures `pad_in` and `drv_hiz` stays low.
- R6: Codes 3'b000 and 3'b010 select high-impedance sampling. `drv_hiz` is high while either code is the instruction, and the boundary register captures `pad_in`.
- R7: The boundary register is 51 cells long, and cell 1 (`pad_in[0]`) is the first bit out on `tdo`.
- R8: Cells 24, 27, 39 and 40 (`pad_in[23]`, `[26]`, `[38]`, `[39]`) are placeholders and always capture 0.
- R9: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only for states SHIFT_DR and SHIFT_IR.
- R10: The instruction, and therefore `drv_hiz`, changes only through APPLY_IR or IDLE_RESET. Data-path scans leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Mode select, sampled on the rising edge of `tck` |
| tdi | input | 1 | Serial data in, sampled on the rising edge of `tck` |
| pad_in | input | BSR_LEN (51) | Pad values captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on the falling edge of `tck` |
| tdo_en | output | 1 | High while `tdo` carries shift data |
| drv_hiz | output | 1 | Request to float the data output drivers |

## Verification
The first bit of any scan appears on `tdo` at the falling edge that follows the rising edge entering a shift state, and each later bit one falling edge after that. A scoreboard monitor therefore samples 2 ns after each falling edge whenever `tdo_en` is high, and compares the sample with the next queued expected bit. `drv_hiz` reflects a new instruction one rising edge after APPLY_IR, and the IDCODE instruction one rising edge after IDLE_RESET. Direct checks are taken only once the controller has reached RUN_IDLE. One check samples `tdo` just after a rising edge to confirm that it holds until the falling edge.

// File: rtl/tap_pkg.sv
package tap_pkg;
    localparam int IR_W = 3;
    localparam int ID_W = 32;
    localparam logic [IR_W-1:0] IR_GRAB_PAT = 3'b001;
    localparam logic [IR_W-1:0] IR_IDCODE   = 3'b001;

    typedef enum logic [3:0] {
        IDLE_RESET, RUN_IDLE,
        PICK_DR, GRAB_DR, SHIFT_DR, EXIT1_DR, PAUSE_DR, EXIT2_DR, APPLY_DR,
        PICK_IR, GRAB_IR, SHIFT_IR, EXIT1_IR, PAUSE_IR, EXIT2_IR, APPLY_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        OP_SAMPZ, OP_IDCODE, OP_SAMPLE, OP_BYPASS
    } tap_op_e;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       tms,
    output tap_state_e state_q,
    output logic       in_reset,
    output logic       grab_ir,
    output logic       shift_ir,
    output logic       apply_ir,
    output logic       grab_dr,
    output logic       shift_dr
);
    tap_state_e state_d;

    always_ff @(posedge tck) begin
        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            IDLE_RESET: state_d = tms ? IDLE_RESET : RUN_IDLE;
            RUN_IDLE:   state_d = tms ? PICK_DR    : RUN_IDLE;
            PICK_DR:    state_d = tms ? PICK_IR    : GRAB_DR;
            GRAB_DR:    state_d = tms ? EXIT1_DR   : SHIFT_DR;
            SHIFT_DR:   state_d = tms ? EXIT1_DR   : SHIFT_DR;
            EXIT1_DR:   state_d = tms ? APPLY_DR   : PAUSE_DR;
            PAUSE_DR:   state_d = tms ? EXIT2_DR   : PAUSE_DR;
            EXIT2_DR:   state_d = tms ? APPLY_DR   : SHIFT_DR;
            APPLY_DR:   state_d = tms ? PICK_DR    : RUN_IDLE;
            PICK_IR:    state_d = tms ? IDLE_RESET : GRAB_IR;
            GRAB_IR:    state_d = tms ? EXIT1_IR   : SHIFT_IR;
            SHIFT_IR:   state_d = tms ? EXIT1_IR   : SHIFT_IR;
            EXIT1_IR:   state_d = tms ? APPLY_IR   : PAUSE_IR;
            PAUSE_IR:   state_d = tms ? EXIT2_IR   : PAUSE_IR;
            EXIT2_IR:   state_d = tms ? APPLY_IR   : SHIFT_IR;
            APPLY_IR:   state_d = tms ? PICK_DR    : RUN_IDLE;
            default:    state_d = IDLE_RESET;
        endcase
    end

    always_comb begin
        in_reset = (state_q == IDLE_RESET);
        grab_ir  = (state_q == GRAB_IR);
        shift_ir = (state_q == SHIFT_IR);
        apply_ir = (state_q == APPLY_IR);
        grab_dr  = (state_q == GRAB_DR);
        shift_dr = (state_q == SHIFT_DR);
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            tdi,
    input  logic            in_reset,
    input  logic            grab_ir,
    input  logic            shift_ir,
    input  logic            apply_ir,
    output logic [IR_W-1:0] ir_q,
    output logic            ir_so,
    output tap_op_e         op,
    output logic            drv_hiz
);
    logic [IR_W-1:0] ir_sh;

    always_ff @(posedge tck) begin
        if (grab_ir)
            ir_sh <= IR_GRAB_PAT;
        else if (shift_ir)
            ir_sh <= {tdi, ir_sh[IR_W-1:1]};
    end

    always_ff @(posedge tck) begin
        if (in_reset)
            ir_q <= IR_IDCODE;
        else if (apply_ir)
            ir_q <= ir_sh;
    end

    always_comb begin
        unique case (ir_q)
            3'b000, 3'b010: op = OP_SAMPZ;
            3'b001:         op = OP_IDCODE;
            3'b100:         op = OP_SAMPLE;
            default:        op = OP_BYPASS;
        endcase
        drv_hiz = (op == OP_SAMPZ);
        ir_so   = ir_sh[0];
    end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int unsigned        BSR_LEN  = 51,
    parameter logic [ID_W-1:0]    ID_VALUE = 32'h0A1B_2C3E,
    parameter logic [BSR_LEN-1:0] PH_MASK  = 51'h0_00C0_0480_0000
) (
    input  logic               tck,
    input  logic               tdi,
    input  logic               grab_dr,
    input  logic               shift_dr,
    input  tap_op_e            op,
    input  logic [BSR_LEN-1:0] pads,
    output logic               dr_so
);
    localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

    logic               byp_q;
    logic [ID_W-1:0]    id_sh;
    logic [BSR_LEN-1:0] bsr_q;
    logic               sel_bsr;

    assign sel_bsr = (op == OP_SAMPLE) || (op == OP_SAMPZ);

    always_ff @(posedge tck) begin
        if (op == OP_BYPASS) begin
            if (grab_dr)
                byp_q <= 1'b0;
            else if (shift_dr)
                byp_q <= tdi;
        end
    end

    always_ff @(posedge tck) begin
        if (op == OP_IDCODE) begin
            if (grab_dr)
                id_sh <= ID_CAP;
            else if (shift_dr)
                id_sh <= {tdi, id_sh[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck) begin
        if (sel_bsr) begin
            if (grab_dr)
                bsr_q <= pads & ~PH_MASK;
            else if (shift_dr)
                bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
        end
    end

    always_comb begin
        unique case (op)
            OP_IDCODE: dr_so = id_sh[0];
            OP_BYPASS: dr_so = byp_q;
            default:   dr_so = bsr_q[0];
        endcase
    end
endmodule

// File: rtl/scan_tap.sv
module scan_tap
    import tap_pkg::*;
#(
    parameter int unsigned        BSR_LEN  = 51,
    parameter logic [ID_W-1:0]    ID_VALUE = 32'h0A1B_2C3E,
    parameter logic [BSR_LEN-1:0] PH_MASK  = 51'h0_00C0_0480_0000
) (
    input  logic               tck,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pad_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               drv_hiz
);
    tap_state_e      state_q;
    logic            in_reset, grab_ir, shift_ir, apply_ir, grab_dr, shift_dr;
    logic [IR_W-1:0] ir_q;
    logic            ir_so, dr_so;
    tap_op_e         op;

    tap_fsm u_fsm (
        .tck(tck), .tms(tms), .state_q(state_q),
        .in_reset(in_reset), .grab_ir(grab_ir), .shift_ir(shift_ir),
        .apply_ir(apply_ir), .grab_dr(grab_dr), .shift_dr(shift_dr)
    );

    tap_ir u_ir (
        .tck(tck), .tdi(tdi), .in_reset(in_reset), .grab_ir(grab_ir),
        .shift_ir(shift_ir), .apply_ir(apply_ir), .ir_q(ir_q),
        .ir_so(ir_so), .op(op), .drv_hiz(drv_hiz)
    );

    tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE), .PH_MASK(PH_MASK)) u_dr (
        .tck(tck), .tdi(tdi), .grab_dr(grab_dr), .shift_dr(shift_dr),
        .op(op), .pads(pad_in), .dr_so(dr_so)
    );

    always_ff @(negedge tck) begin
        tdo    <= shift_ir ? ir_so : dr_so;
        tdo_en <= shift_ir | shift_dr;
    end
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            tms,
    input tap_state_e      state,
    input logic [IR_W-1:0] ir_q,
    input logic            tdo_en,
    input logic            drv_hiz
);
    logic [2:0] hi_cnt = 3'd0;
    logic       synced = 1'b0;

    always_ff @(posedge tck) begin
        if (!tms)
            hi_cnt <= 3'd0;
        else if (hi_cnt != 3'd5)
            hi_cnt <= hi_cnt + 3'd1;
        synced <= synced | (hi_cnt == 3'd5);
    end

    // R1
    five_high_reset_chk: assert property (@(posedge tck) disable iff (!synced)
        (hi_cnt == 3'd5) |-> (state == IDLE_RESET));

    // R2
    reset_idcode_chk: assert property (@(posedge tck) disable iff (!synced)
        ($past(state) == IDLE_RESET) |-> (ir_q == IR_IDCODE));

    // R9
    tdo_en_window_chk: assert property (@(posedge tck) disable iff (!synced)
        tdo_en == ((state == SHIFT_DR) || (state == SHIFT_IR)));

    // R10
    ir_change_src_chk: assert property (@(posedge tck) disable iff (!synced)
        !$stable(ir_q) |-> (($past(state) == APPLY_IR) || ($past(state) == IDLE_RESET)));

    // R6
    hiz_follows_ir_chk: assert property (@(posedge tck) disable iff (!synced)
        !$stable(drv_hiz) |-> !$stable(ir_q));
endmodule

bind scan_tap scan_tap_chk chk_i (
    .tck(tck), .tms(tms), .state(state_q), .ir_q(ir_q),
    .tdo_en(tdo_en), .drv_hiz(drv_hiz)
);

// File: tb/scan_tap_tb_top.sv
`timescale 1ns/1ps
module scan_tap_tb_top;
    localparam int          BSR_N = 51;
    localparam logic [31:0] ID_P  = 32'h0A1B_2C3E;

    logic             tck = 1'b0;
    logic             tms = 1'b1;
    logic             tdi = 1'b0;
    logic [BSR_N-1:0] pads = '0;
    logic             tdo, tdo_en, drv_hiz;
    logic [BSR_N-1:0] ph_m;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;
    bit    exp_q[$];
    string tag_q[$];

    always #4 tck = ~tck;

    scan_tap #(.BSR_LEN(BSR_N), .ID_VALUE(ID_P)) dut_i (
        .tck(tck), .tms(tms), .tdi(tdi), .pad_in(pads),
        .tdo(tdo), .tdo_en(tdo_en), .drv_hiz(drv_hiz)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: one expected bit per falling edge with tdo_en high
    always begin
        bit    e;
        string t;
        @(negedge tck);
        #2;
        if (tdo_en === 1'b1) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected shift bit", {63'd0, tdo}, 64'd0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(tdo === e, t, {63'd0, tdo}, {63'd0, e});
            end
        end
    end

    task automatic push_bits(input logic [63:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v[i]);
            tag_q.push_back(tag);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge tck);
        @(negedge tck);
        #1;
    endtask

    task automatic load_ir(input logic [2:0] code);
        tick(1, 0); tick(1, 0); tick(0, 0);
        push_bits(64'b001, 3, "R3 grab pattern");
        tick(0, 0);
        for (int i = 0; i < 3; i++) tick(i == 2, code[i]);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din);
        tick(1, 0); tick(0, 0); tick(0, 0);
        for (int i = 0; i < n; i++) tick(i == n - 1, din[i]);
        tick(1, 0); tick(0, 0);
    endtask

    task automatic push_bsr(input logic [BSR_N-1:0] p, input string tag);
        logic [BSR_N-1:0] e;
        e = p & ~ph_m;
        for (int i = 0; i < BSR_N; i++) begin
            exp_q.push_back(e[i]);
            tag_q.push_back(ph_m[i] ? "R8 placeholder" : tag);
        end
    endtask

    task automatic bypass_scan(input logic [7:0] din);
        push_bits({56'd0, din[6:0], 1'b0}, 8, "R4 bypass");
        scan_dr(8, {56'd0, din});
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            check(1'b0, "watchdog", 64'd0, 64'd1);
            summary();
            $finish;
        end
    end

    initial begin
        ph_m = '0;
        ph_m[23] = 1'b1; ph_m[26] = 1'b1; ph_m[38] = 1'b1; ph_m[39] = 1'b1;

        // R1: reset through mode select
        repeat (5) tick(1, 0);
        tick(0, 0);
        check(tdo_en == 1'b0, "R1 tdo_en idle", {63'd0, tdo_en}, 64'd0);
        check(drv_hiz == 1'b0, "R2 no hiz after reset", {63'd0, drv_hiz}, 64'd0);

        // R2: identification word
        push_bits({32'd0, ID_P | 32'd1}, 32, "R2 idcode");
        scan_dr(32, 64'hFFFF_0000);

        // R4: every bypass alias
        load_ir(3'b011); bypass_scan(8'b1011_0010);
        load_ir(3'b101); bypass_scan(8'b0110_1101);
        load_ir(3'b110); bypass_scan(8'b1111_0001);
        load_ir(3'b111); bypass_scan(8'b0101_0111);

        // R5 R7 R8: sampling
        load_ir(3'b100);
        check(drv_hiz == 1'b0, "R5 sample no hiz", {63'd0, drv_hiz}, 64'd0);
        pads = 51'h5_A5A5_F00F_3C3C | ph_m;
        push_bsr(pads, "R7 order");
        scan_dr(BSR_N, 64'd0);

        // R6 R10: sampling with float request
        load_ir(3'b000);
        check(drv_hiz == 1'b1, "R6 code 000 hiz", {63'd0, drv_hiz}, 64'd1);
        pads = 51'h2_3C81_7E55_9AC3 | ph_m;
        push_bsr(pads, "R6 capture");
        scan_dr(BSR_N, 64'hFFFF_FFFF_FFFF_FFFF);
        check(drv_hiz == 1'b1, "R10 hiz kept after DR scan", {63'd0, drv_hiz}, 64'd1);
        load_ir(3'b010);
        check(drv_hiz == 1'b1, "R6 code 010 hiz", {63'd0, drv_hiz}, 64'd1);

        // R9: tdo holds through rising edge, moves on falling edge
        load_ir(3'b011);
        check(drv_hiz == 1'b0, "R4 bypass no hiz", {63'd0, drv_hiz}, 64'd0);
        tick(1, 0); tick(0, 0);
        push_bits(64'b10, 2, "R9 falling edge data");
        tick(0, 0);
        tms = 0; tdi = 1;
        @(posedge tck); #1;
        check(tdo == 1'b0, "R9 tdo held past rising edge", {63'd0, tdo}, 64'd0);
        @(negedge tck); #1;
        tick(1, 0); tick(1, 0); tick(0, 0);
        check(tdo_en == 1'b0, "R9 tdo_en low outside shift", {63'd0, tdo_en}, 64'd0);

        // R1: reset from inside a data shift
        load_ir(3'b010);
        tick(1, 0); tick(0, 0);
        push_bits({63'd0, pads[0]}, 1, "R1 pre-reset bit");
        tick(0, 0);
        repeat (5) tick(1, 0);
        check(tdo_en == 1'b0, "R1 tdo_en after reset", {63'd0, tdo_en}, 64'd0);
        tick(0, 0);
        check(drv_hiz == 1'b0, "R1 instruction reset", {63'd0, drv_hiz}, 64'd0);
        push_bits({32'd0, ID_P | 32'd1}, 32, "R2 idcode after reset");
        scan_dr(32, 64'd0);

        check(exp_q.size() == 0, "R9 all expected bits seen", exp_q.size(), 64'd0);
        done = 1;
        summary();
        $finish;
    end
endmodule